// File: doc/BRIEF.md
# Credited Channel Transmitter with Resource Planes

This block is the sending end of one credit-controlled channel. The channel is split into a configurable number of resource planes, from 1 to 8, and each plane has its own pool of dedicated credits. An optional shared pool can pay for a transfer on any plane. The receiver returns credits one pulse at a time: one line per plane for dedicated credits and one line for shared credits. The transmitter keeps a registered count of each pool and launches a transfer only when it already holds a suitable credit. It never waits for a same-cycle acknowledgement.

Upstream producers offer transfers through one valid/ready port per plane. An arbiter chooses one eligible plane per cycle. It is round-robin by default, and a parameter switches it to fixed priority. A plane is eligible when it has a request, the look-ahead flag is already up, and it holds a dedicated credit or a shared credit is available. The winning transfer appears on registered outputs in the next cycle, together with its plane number and a flag that says whether a shared credit paid for it. A registered look-ahead output warns the receiver one cycle before any transfer. This look-ahead does not depend on credit ownership.

With one plane, the plane output is tied to zero and shared credits must be disabled.

Top module: `ctx_credit_tx`

## Requirements
- R1: While reset is active and in the first cycle after it, `tx_valid`, `tx_shared` and `tx_pending` are 0 and every credit count is zero. A request offered with no credit ever given never produces a transfer.
- R2: Each cycle with `crdt_in[n]` high adds exactly one dedicated credit to plane n, and each cycle with `crdt_sh_in` high adds exactly one shared credit. Plane n sends exactly as many transfers as the credits it was given when no shared credit exists.
- R3: A credit given in cycle t is never spent before cycle t+1. With `tx_pending` already high, the earliest `tx_valid` it can pay for is in cycle t+2.
- R4: A transfer on plane n spends a plane-n dedicated credit when the count is nonzero. Otherwise it spends a shared credit, and `tx_shared` is 1 in the same cycle as `tx_valid`. `tx_shared` is 0 whenever `tx_valid` is 0.
- R5: While `tx_valid` is 1, `tx_plane` holds the binary number of the plane the transfer came from. This holds even when a shared credit pays for it.
- R6: `tx_valid` is 1 in a cycle only if `tx_pending` was 1 in the previous cycle.
- R7: `tx_pending` in cycle t+1 equals the OR of `req_valid` in cycle t, whatever credits are held. It may therefore rise and then fall without any transfer.
- R8: A plane with a request but no usable credit never stops another eligible plane from sending. Among eligible planes, the grant goes to the first one found in ascending index order, wrapping around, starting after the previous winner (plane 0 first after reset).
- R9: Each counter holds up to 15 credits, and all 15 can be spent. A credit that arrives while a counter holds 15 and is not spending is flagged as a protocol error.
- R10: `req_ready[n]` is 1 in exactly the cycle in which plane n is granted, never without `req_valid[n]`, and for at most one plane. `tx_data` in the next cycle equals the payload that plane offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | NUM_PLANES | Per-plane upstream request |
| req_ready | output | NUM_PLANES | Per-plane acceptance of the offered request |
| req_data | input | NUM_PLANES*DATA_W | Per-plane payloads, plane n at bits n*DATA_W upward |
| crdt_in | input | NUM_PLANES | Dedicated credit pulse per plane |
| crdt_sh_in | input | 1 | Shared credit pulse |
| tx_pending | output | 1 | Look-ahead: a transfer may occur next cycle |
| tx_valid | output | 1 | Transfer present this cycle |
| tx_plane | output | PLANE_W | Plane number of the transfer |
| tx_shared | output | 1 | Transfer is paid for with a shared credit |
| tx_data | output | DATA_W | Transfer payload |

## Verification
The sequence starts with a request and no credits, to show that the look-ahead rises while nothing is sent. It then sends a single dedicated credit, which separates the credit-arrival cycle from the earliest launch cycle. A run with one dedicated credit and two shared credits on one plane tells the dedicated-first policy apart from shared-first spending. A plane starved of credits is placed beside a credited plane, and later all three planes compete, which separates a blocking arbiter from an independent one and shows the rotation order. A burst of fifteen credits on one plane exercises the top of the counter range. A reference model advances with every clock and predicts the ready lines, the look-ahead and each transfer field.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

   // upper bound on the number of resource planes
   localparam int unsigned CTX_MAX_PLANES = 8;
   // largest credit count any pool needs to hold
   localparam int unsigned CTX_CRED_LIMIT = 15;

   // width of a plane index; one bit minimum so ports stay legal
   function automatic int unsigned ctx_idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/ctx_credit_cnt.sv
module ctx_credit_cnt #(
   parameter int unsigned CNT_W    = 4,
   parameter int unsigned CRED_MAX = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             give,
   input  logic             take,
   output logic [CNT_W-1:0] count,
   output logic             avail
);

   localparam logic [CNT_W-1:0] TOP = CNT_W'(CRED_MAX);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (give && !take) begin
         if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
      end else if (take && !give) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign count = cnt_q;
   assign avail = (cnt_q != '0);

endmodule

// File: rtl/ctx_plane_arb.sv
module ctx_plane_arb #(
   parameter int unsigned N           = 3,
   parameter int unsigned IDX_W       = 2,
   parameter bit          ROUND_ROBIN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     elig,
   output logic [N-1:0]     grant,
   output logic             any,
   output logic [IDX_W-1:0] win
);

   logic [IDX_W-1:0] base;

   generate
      if (ROUND_ROBIN) begin : g_rr
         logic [IDX_W-1:0] last_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   last_q <= IDX_W'(N - 1);
            else if (any) last_q <= win;
         end
         assign base = last_q;
      end else begin : g_fixed
         // search always starts at plane 0
         assign base = IDX_W'(N - 1);
      end
   endgenerate

   always_comb begin
      grant = '0;
      any   = 1'b0;
      win   = '0;
      for (int i = 0; i < int'(N); i++) begin
         int p;
         p = (int'(base) + 1 + i) % int'(N);
         if (!any && elig[p]) begin
            any      = 1'b1;
            grant[p] = 1'b1;
            win      = IDX_W'(p);
         end
      end
   end

endmodule

// File: rtl/ctx_credit_tx.sv
module ctx_credit_tx
   import ctx_pkg::*;
#(
   parameter int unsigned NUM_PLANES  = 3,
   parameter bit          SHARED_EN   = 1'b1,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned CRED_MAX    = 15,
   parameter bit          ROUND_ROBIN = 1'b1,
   localparam int unsigned PLANE_W    = ctx_idx_w(NUM_PLANES),
   localparam int unsigned CNT_W      = $clog2(CRED_MAX + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_PLANES-1:0]        req_valid,
   output logic [NUM_PLANES-1:0]        req_ready,
   input  logic [NUM_PLANES*DATA_W-1:0] req_data,
   input  logic [NUM_PLANES-1:0]        crdt_in,
   input  logic                         crdt_sh_in,
   output logic                         tx_pending,
   output logic                         tx_valid,
   output logic [PLANE_W-1:0]           tx_plane,
   output logic                         tx_shared,
   output logic [DATA_W-1:0]            tx_data
);

   // ---------------- elaboration checks ----------------
   generate
      if (NUM_PLANES < 1 || NUM_PLANES > CTX_MAX_PLANES) begin : g_bad_planes
         $error("ctx_credit_tx: NUM_PLANES out of range");
      end
      if (CRED_MAX < 1 || CRED_MAX > CTX_CRED_LIMIT) begin : g_bad_cred
         $error("ctx_credit_tx: CRED_MAX out of range");
      end
      if (SHARED_EN && NUM_PLANES < 2) begin : g_bad_shared
         $error("ctx_credit_tx: shared pool needs two or more planes");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("ctx_credit_tx: DATA_W must be positive");
      end
   endgenerate

   // ---------------- credit pools ----------------
   logic [NUM_PLANES-1:0]       ded_avail;
   logic [NUM_PLANES-1:0]       ded_take;
   logic [NUM_PLANES*CNT_W-1:0] ded_cnt;
   logic                        sh_avail;
   logic                        sh_take;
   logic [CNT_W-1:0]            sh_cnt;

   generate
      for (genvar n = 0; n < NUM_PLANES; n++) begin : g_plane_cnt
         ctx_credit_cnt #(.CNT_W(CNT_W), .CRED_MAX(CRED_MAX)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .give  (crdt_in[n]),
            .take  (ded_take[n]),
            .count (ded_cnt[n*CNT_W +: CNT_W]),
            .avail (ded_avail[n])
         );
      end

      if (SHARED_EN) begin : g_shared
         ctx_credit_cnt #(.CNT_W(CNT_W), .CRED_MAX(CRED_MAX)) u_sh_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .give  (crdt_sh_in),
            .take  (sh_take),
            .count (sh_cnt),
            .avail (sh_avail)
         );
      end else begin : g_no_shared
         // shared pulses are ignored when no shared pool exists
         logic unused_sh;
         assign unused_sh = crdt_sh_in;
         assign sh_cnt    = '0;
         assign sh_avail  = 1'b0;
      end
   endgenerate

   // ---------------- look-ahead ----------------
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= |req_valid;
   end

   // ---------------- eligibility and arbitration ----------------
   logic [NUM_PLANES-1:0] elig;
   logic [NUM_PLANES-1:0] grant;
   logic                  any_grant;
   logic [PLANE_W-1:0]    win;

   // a launch is only allowed while the look-ahead is already up
   assign elig = req_valid & {NUM_PLANES{pend_q}} &
                 (ded_avail | {NUM_PLANES{sh_avail}});

   ctx_plane_arb #(.N(NUM_PLANES), .IDX_W(PLANE_W), .ROUND_ROBIN(ROUND_ROBIN)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .elig  (elig),
      .grant (grant),
      .any   (any_grant),
      .win   (win)
   );

   // dedicated credit first, shared only when the plane has none
   assign ded_take  = grant & ded_avail;
   assign sh_take   = any_grant & ~(|ded_take);
   assign req_ready = grant;

   // ---------------- output stage ----------------
   logic [DATA_W-1:0]  data_sel;
   logic               valid_q;
   logic               shared_q;
   logic [PLANE_W-1:0] plane_q;
   logic [DATA_W-1:0]  data_q;

   always_comb begin
      data_sel = '0;
      for (int n = 0; n < int'(NUM_PLANES); n++) begin
         if (grant[n]) data_sel = req_data[n*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q  <= 1'b0;
         shared_q <= 1'b0;
         plane_q  <= '0;
         data_q   <= '0;
      end else begin
         valid_q  <= any_grant;
         shared_q <= sh_take;
         if (any_grant) begin
            plane_q <= win;
            data_q  <= data_sel;
         end
      end
   end

   generate
      if (NUM_PLANES > 1) begin : g_plane_out
         assign tx_plane = plane_q;
      end else begin : g_plane_tie
         logic unused_plane;
         assign unused_plane = |plane_q;
         assign tx_plane     = '0;
      end
   endgenerate

   assign tx_pending = pend_q;
   assign tx_valid   = valid_q;
   assign tx_shared  = shared_q;
   assign tx_data    = data_q;

endmodule

// File: rtl/ctx_credit_tx_chk.sv
module ctx_credit_tx_chk #(
   parameter int unsigned NP       = 3,
   parameter int unsigned CNT_W    = 4,
   parameter int unsigned CRED_MAX = 15,
   parameter bit          SH_EN    = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NP-1:0]       req_valid,
   input logic [NP-1:0]       req_ready,
   input logic [NP-1:0]       crdt_in,
   input logic                crdt_sh_in,
   input logic                tx_pending,
   input logic                tx_valid,
   input logic                tx_shared,
   input logic [NP*CNT_W-1:0] ded_cnt,
   input logic [CNT_W-1:0]    sh_cnt,
   input logic [NP-1:0]       ded_take,
   input logic                sh_take
);

   localparam logic [CNT_W-1:0] TOP = CNT_W'(CRED_MAX);

   // R1
   reset_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (!tx_valid && !tx_shared && !tx_pending));

   // R6
   pending_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(tx_pending));

   // R4
   shared_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_shared |-> tx_valid);

   // R10
   ready_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_ready) && ((req_ready & ~req_valid) == '0));

   // R4
   shared_spend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sh_take |-> (sh_cnt != '0));

   generate
      for (genvar n = 0; n < NP; n++) begin : g_plane_chk
         // R3
         held_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ded_take[n] |-> (ded_cnt[n*CNT_W +: CNT_W] != '0));
         // R9
         no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !((ded_cnt[n*CNT_W +: CNT_W] == TOP) && crdt_in[n] && !ded_take[n]));
      end
      if (SH_EN) begin : g_sh_chk
         // R9
         no_sh_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !((sh_cnt == TOP) && crdt_sh_in && !sh_take));
      end
   endgenerate

endmodule

bind ctx_credit_tx ctx_credit_tx_chk #(
   .NP       (NUM_PLANES),
   .CNT_W    (CNT_W),
   .CRED_MAX (CRED_MAX),
   .SH_EN    (SHARED_EN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .crdt_in    (crdt_in),
   .crdt_sh_in (crdt_sh_in),
   .tx_pending (tx_pending),
   .tx_valid   (tx_valid),
   .tx_shared  (tx_shared),
   .ded_cnt    (ded_cnt),
   .sh_cnt     (sh_cnt),
   .ded_take   (ded_take),
   .sh_take    (sh_take)
);

// File: tb/ctx_credit_tx_test.sv
module ctx_credit_tx_test;

   localparam int NP = 3;
   localparam int DW = 16;
   localparam int PW = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NP-1:0]    req_valid = '0;
   logic [NP-1:0]    req_ready;
   logic [NP*DW-1:0] req_data = '0;
   logic [NP-1:0]    crdt_in = '0;
   logic             crdt_sh_in = 1'b0;
   logic             tx_pending, tx_valid, tx_shared;
   logic [PW-1:0]    tx_plane;
   logic [DW-1:0]    tx_data;

   always #4 clk = ~clk;

   ctx_credit_tx #(.NUM_PLANES(NP), .SHARED_EN(1'b1), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_data(req_data), .crdt_in(crdt_in), .crdt_sh_in(crdt_sh_in),
      .tx_pending(tx_pending), .tx_valid(tx_valid), .tx_plane(tx_plane),
      .tx_shared(tx_shared), .tx_data(tx_data));

   int n_run = 0;
   int n_fail = 0;

   // upstream sources and reference model state
   logic [DW-1:0] q [NP][$];
   logic [NP-1:0] mask = '1;
   int  ded [NP];
   int  sh = 0;
   bit  pm = 0;
   int  ptr = NP - 1;
   bit  ev = 0, es = 0, epend = 0, prev_pend = 0;
   int  ep = 0;
   int  ed = 0;
   int  sent [NP];
   int  sent_sh = 0;
   int  seq = 1;

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic push(input int p, input int cnt);
      for (int i = 0; i < cnt; i++) begin
         q[p].push_back(DW'(seq * 37 + p));
         seq++;
      end
   endtask

   // one clock cycle: compare outputs, drive inputs, predict the next edge
   task automatic cyc(input logic [NP-1:0] cr, input logic crs);
      logic [NP-1:0] rv;
      logic [NP-1:0] exp_rdy;
      int win;
      @(negedge clk);
      chk("R6 valid without prior pending", (tx_valid && !prev_pend) ? 1 : 0, 0);
      chk("R3 tx_valid", tx_valid, ev);
      chk("R7 tx_pending", tx_pending, epend);
      chk("R4 tx_shared", tx_shared, es);
      if (ev) begin
         chk("R5 tx_plane", tx_plane, ep);
         chk("R10 tx_data", tx_data, ed);
      end
      if (tx_valid) begin
         sent[tx_plane]++;
         if (tx_shared) sent_sh++;
      end
      prev_pend = tx_pending;
      for (int p = 0; p < NP; p++) begin
         rv[p] = (q[p].size() > 0) && mask[p];
         req_data[p*DW +: DW] = (q[p].size() > 0) ? q[p][0] : '0;
      end
      req_valid  = rv;
      crdt_in    = cr;
      crdt_sh_in = crs;
      #1;
      win = -1;
      for (int i = 0; i < NP; i++) begin
         int p;
         p = (ptr + 1 + i) % NP;
         if (win < 0 && rv[p] && pm && (ded[p] > 0 || sh > 0)) win = p;
      end
      exp_rdy = (win >= 0) ? NP'(1 << win) : '0;
      chk("R8 req_ready grant", req_ready, exp_rdy);
      if (win >= 0) begin
         ev = 1; ep = win; ed = q[win].pop_front(); ptr = win;
         if (ded[win] > 0) begin ded[win]--; es = 0; end
         else begin sh--; es = 1; end
      end else begin
         ev = 0; es = 0;
      end
      for (int p = 0; p < NP; p++) if (cr[p] && ded[p] < 15) ded[p]++;
      if (crs && sh < 15) sh++;
      epend = |rv;
      pm    = |rv;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc('0, 1'b0);
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog R1-chain actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int s0, s1, sh0;
      for (int p = 0; p < NP; p++) begin ded[p] = 0; sent[p] = 0; end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 reset tx_valid", tx_valid, 0);
      chk("R1 reset tx_pending", tx_pending, 0);
      chk("R1 reset tx_shared", tx_shared, 0);
      rst_n = 1'b1;

      // R1: request with no credits never transfers; R7: pending still rises
      push(0, 1);
      idle(4);
      chk("R1 no transfer without credit", sent[0], 0);
      chk("R7 pending without credit", tx_pending, 1);

      // R3: one credit on plane 0, earliest use two cycles later
      cyc(3'b001, 1'b0);
      cyc('0, 1'b0);
      chk("R3 credit not spent early", tx_valid, 0);
      cyc('0, 1'b0);
      chk("R3 credit spent next cycle", tx_valid, 1);
      idle(2);

      // R2: two dedicated credits on plane 1, four requests
      s1 = sent[1];
      push(1, 4);
      cyc(3'b010, 1'b0);
      cyc(3'b010, 1'b0);
      idle(8);
      chk("R2 transfers equal dedicated credits", sent[1] - s1, 2);
      q[1].delete();
      idle(3);

      // R4: plane 2 has one dedicated and two shared credits
      s0 = sent[2]; sh0 = sent_sh;
      cyc(3'b100, 1'b1);
      cyc('0, 1'b1);
      push(2, 3);
      idle(8);
      chk("R4 plane 2 transfers", sent[2] - s0, 3);
      chk("R4 shared credits spent", sent_sh - sh0, 2);

      // R7: pending falls when request withdrawn, no transfer follows
      push(0, 1);
      idle(3);
      mask = 3'b000;
      s0 = sent[0];
      idle(3);
      chk("R7 pending dropped", tx_pending, 0);
      chk("R7 no transfer after withdrawal", sent[0] - s0, 0);
      mask = 3'b111;

      // R8: starved plane 0 does not block plane 2
      s1 = sent[2];
      push(2, 2);
      cyc(3'b100, 1'b0);
      cyc(3'b100, 1'b0);
      idle(6);
      chk("R8 credited plane progresses", sent[2] - s1, 2);
      chk("R8 starved plane waits", q[0].size(), 1);

      // R8: all planes compete, rotation checked cycle by cycle
      push(0, 1); push(1, 2); push(2, 2);
      cyc(3'b111, 1'b0);
      cyc(3'b111, 1'b0);
      idle(10);
      chk("R8 all queues drained", q[0].size() + q[1].size() + q[2].size(), 0);

      // R9: fifteen credits on plane 1, all usable
      for (int i = 0; i < 15; i++) cyc(3'b010, 1'b0);
      s1 = sent[1]; sh0 = sent_sh;
      push(1, 15);
      idle(25);
      chk("R9 fifteen credits spent", sent[1] - s1, 15);
      chk("R9 no shared used", sent_sh - sh0, 0);
      idle(2);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule